// File: doc/BRIEF.md
# Interrupt Request Routing Crossbar

This block sits between a large population of peripheral interrupt sources and the input lines of an interrupt controller. Every controller input line owns a select register that names the source it forwards. Software writes these registers over a simple register bus, and each routed line copies the level of its chosen source through one output flop. A select value that names no existing source drives the line low.

Each line belongs to one of three kinds, and the kind is fixed when the block is built. A routed line (LK_MUX) takes its level from the mux. A reserved line (LK_RSV) has no select register. It forwards its dedicated hard-wired input, ignores writes, and reads back the safe source index. A skipped line (LK_SKIP) keeps a select register that can be written and read back, but its output still comes from its hard-wired input. The only transitions a select register makes are two: on reset it loads the safe index, and on an accepted write it loads the written value.

Select registers are laid out at byte offset `line × REG_BYTES`. Reads return data one cycle after the request.

Top module: `irq_xbar`

## Requirements
- R1: While reset is asserted, every output line is low. After reset, every select register reads back the safe index `SAFE_SEL` (default 0).
- R2: On a routed line whose select value is below `N_SRC`, the output after a clock edge equals the level that the selected source had at that edge. The output always follows exactly one register stage behind the source.
- R3: A write to byte offset `line × REG_BYTES` (default 2 bytes per register) is stored at the write edge. The output uses the new selection from the following edge onward, and a later read returns the written value.
- R4: A routed line whose select value is `N_SRC` or above drives low. This holds even when the low bits of the value alias a valid source index (for example 0x1025 with 400 sources).
- R5: A reserved line forwards its `fixed_i` bit with one register stage. Writes to its select register are ignored, and reads of it return `SAFE_SEL`. Default reserved lines: 0, 1, 2, 3, 5, 6, 131, 132.
- R6: A skipped line stores and reads back select writes, but its output forwards its `fixed_i` bit with one register stage and never the mux. Default skipped lines: 10, 133, 139, 140.
- R7: `rdata` is loaded at the edge that samples `rd_en`. When a read and a write hit the same register in the same cycle, the read returns the value held before the write.
- R8: An access whose offset is not a multiple of `REG_BYTES`, or whose offset is at or beyond `N_OUT × REG_BYTES`, reads as zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC (400) | Level-sensitive peripheral interrupt sources |
| fixed_i | input | N_OUT (160) | Hard-wired interrupts for reserved and skipped lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (10) | Byte offset into the select register window |
| wdata | input | REG_BYTES×8 (16) | Write data |
| rdata | output | REG_BYTES×8 (16) | Read data, valid the cycle after `rd_en` |
| irq_o | output | N_OUT (160) | Lines to the interrupt controller |

## Verification
The risky overlap is a register access arriving in the same cycle as a change in what the output forwards. In one case the bench asserts read and write to the same select register in a single cycle. It expects the old value on `rdata` and expects the line to keep its old source for one more cycle before it switches. In the other case it rewrites a select register while the old and new sources have different levels. The scoreboard then expects the old level one cycle after the write and the new level one cycle later.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;

    typedef enum logic [1:0] {
        LK_MUX  = 2'd0,
        LK_RSV  = 2'd1,
        LK_SKIP = 2'd2
    } line_kind_e;

    // Reserved beats skipped when a line is flagged in both masks.
    function automatic line_kind_e kind_of(input logic rsv, input logic skip);
        if (rsv) begin
            return LK_RSV;
        end
        if (skip) begin
            return LK_SKIP;
        end
        return LK_MUX;
    endfunction

endpackage

// File: rtl/irq_xbar_decode.sv
module irq_xbar_decode #(
    parameter int ADDR_W    = 10,
    parameter int REG_BYTES = 2,
    parameter int N_OUT     = 160,
    parameter int LINE_W    = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [LINE_W-1:0] line_o,
    output logic              hit_o
);
    localparam int LG = $clog2(REG_BYTES);

    logic [ADDR_W-1:0] word;
    logic              aligned;

    assign word    = addr_i >> LG;
    assign aligned = (addr_i & ADDR_W'(REG_BYTES - 1)) == '0;
    assign hit_o   = aligned && (word < ADDR_W'(N_OUT));
    assign line_o  = word[LINE_W-1:0];

endmodule

// File: rtl/irq_xbar_regs.sv
module irq_xbar_regs #(
    parameter int              N_OUT    = 160,
    parameter int              REG_W    = 16,
    parameter int              LINE_W   = 8,
    parameter int              SAFE_SEL = 0,
    parameter logic [N_OUT-1:0] RSV_MASK = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic                        hit,
    input  logic [LINE_W-1:0]           line,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output logic [N_OUT-1:0][REG_W-1:0] sel_o
);
    localparam logic [REG_W-1:0] SAFE = REG_W'(SAFE_SEL);

    for (genvar i = 0; i < N_OUT; i++) begin : g_sel
        if (RSV_MASK[i]) begin : g_rsv
            assign sel_o[i] = SAFE;
        end else begin : g_reg
            logic [REG_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= SAFE;
                end else if (wr_en && hit && line == LINE_W'(i)) begin
                    q <= wdata;
                end
            end
            assign sel_o[i] = q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= hit ? sel_o[line] : '0;
        end
    end

    // R3
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !RSV_MASK[line]) |=> sel_o[$past(line)] == $past(wdata));

    // R7
    rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit) |=> rdata == $past(sel_o[line]));

    // R8
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> rdata == '0);

endmodule

// File: rtl/irq_xbar_lane.sv
module irq_xbar_lane
    import irq_xbar_pkg::*;
#(
    parameter int         N_SRC = 400,
    parameter int         REG_W = 16,
    parameter int         SRC_W = 9,
    parameter line_kind_e KIND  = LK_MUX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [REG_W-1:0] sel_i,
    input  logic             fixed_i,
    output logic             irq_o
);
    logic [31:0]      sel_ext;
    logic             in_range;
    logic [SRC_W-1:0] idx;
    logic             pick;
    logic             nxt;

    assign sel_ext  = 32'(sel_i);
    assign in_range = sel_ext < 32'(N_SRC);
    assign idx      = sel_ext[SRC_W-1:0];
    assign pick     = in_range ? src_i[idx] : 1'b0;

    always_comb begin
        unique case (KIND)
            LK_MUX:          nxt = pick;
            LK_RSV, LK_SKIP: nxt = fixed_i;
            default:         nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= nxt;
        end
    end

    // R2
    mux_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == LK_MUX && in_range) |=> irq_o == $past(pick));

    // R4
    oor_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == LK_MUX && sel_ext >= 32'(N_SRC)) |=> !irq_o);

    // R5 R6
    fixed_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND != LK_MUX) |=> irq_o == $past(fixed_i));

endmodule

// File: rtl/irq_xbar.sv
module irq_xbar
    import irq_xbar_pkg::*;
#(
    parameter int               N_SRC     = 400,
    parameter int               N_OUT     = 160,
    parameter int               REG_BYTES = 2,
    parameter int               ADDR_W    = 10,
    parameter int               SAFE_SEL  = 0,
    parameter logic [N_OUT-1:0] RSV_MASK  =
        160'h000000_18_0000000000_0000000000_0000000000_6F,
    parameter logic [N_OUT-1:0] SKIP_MASK =
        160'h0000_182_0000000000_0000000000_0000000000_400
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         src_i,
    input  logic [N_OUT-1:0]         fixed_i,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_BYTES*8-1:0]   wdata,
    output logic [REG_BYTES*8-1:0]   rdata,
    output logic [N_OUT-1:0]         irq_o
);
    localparam int REG_W  = REG_BYTES * 8;
    localparam int LINE_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    if (REG_BYTES != 1 && REG_BYTES != 2 && REG_BYTES != 4) begin : g_bad_width
        $error("irq_xbar: REG_BYTES must be 1, 2 or 4");
    end

    logic [LINE_W-1:0]           line;
    logic                        hit;
    logic [N_OUT-1:0][REG_W-1:0] sel;

    irq_xbar_decode #(
        .ADDR_W    (ADDR_W),
        .REG_BYTES (REG_BYTES),
        .N_OUT     (N_OUT),
        .LINE_W    (LINE_W)
    ) u_decode (
        .addr_i (addr),
        .line_o (line),
        .hit_o  (hit)
    );

    irq_xbar_regs #(
        .N_OUT    (N_OUT),
        .REG_W    (REG_W),
        .LINE_W   (LINE_W),
        .SAFE_SEL (SAFE_SEL),
        .RSV_MASK (RSV_MASK)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .hit   (hit),
        .line  (line),
        .wdata (wdata),
        .rdata (rdata),
        .sel_o (sel)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        localparam line_kind_e K = kind_of(RSV_MASK[i], SKIP_MASK[i]);
        irq_xbar_lane #(
            .N_SRC (N_SRC),
            .REG_W (REG_W),
            .SRC_W (SRC_W),
            .KIND  (K)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i),
            .sel_i   (sel[i]),
            .fixed_i (fixed_i[i]),
            .irq_o   (irq_o[i])
        );
    end

endmodule

// File: tb/test_irq_xbar.sv
module test_irq_xbar;
    localparam int N_SRC  = 400;
    localparam int N_OUT  = 160;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src = '0;
    logic [N_OUT-1:0]  fixed = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [REG_W-1:0]  wdata = '0;
    logic [REG_W-1:0]  rdata;
    logic [N_OUT-1:0]  irq_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int          due;
        int          kind;
        int          line;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    irq_xbar i_irq_xbar (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .fixed_i (fixed),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_o   (irq_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare every scoreboard item that falls due in this cycle.
    always @(negedge clk) begin
        for (int k = sb_q.size() - 1; k >= 0; k--) begin
            if (sb_q[k].due == cyc) begin
                if (sb_q[k].kind == 0) begin
                    chk(sb_q[k].req, {31'b0, irq_o[sb_q[k].line]}, sb_q[k].exp);
                end else begin
                    chk(sb_q[k].req, 32'(rdata), sb_q[k].exp);
                end
                sb_q.delete(k);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic exp_out(int line, int dly, logic v, string req);
        item_t it;
        it = '{cyc + dly, 0, line, {31'b0, v}, req};
        sb_q.push_back(it);
    endtask

    task automatic exp_rd(int dly, logic [31:0] v, string req);
        item_t it;
        it = '{cyc + dly, 1, 0, v, req};
        sb_q.push_back(it);
    endtask

    task automatic wr(int a, logic [REG_W-1:0] d);
        wr_en = 1'b1;
        addr  = ADDR_W'(a);
        wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] e, string req);
        rd_en = 1'b1;
        addr  = ADDR_W'(a);
        exp_rd(1, e, req);
        step();
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        step(); step(); step();
        // R1: outputs low during reset
        chk("R1 reset outputs", {31'b0, irq_o == '0}, 32'd1);
        rst_n = 1'b1;
        step();
        rd(4 * 2, 0, "R1 safe readback line 4");
        rd(10 * 2, 0, "R1 safe readback line 10");
        rd(0, 0, "R5 reserved line 0 reads safe");

        // R2: default routing follows source 0
        src[0] = 1'b1;
        exp_out(4, 1, 1'b1, "R2 line 4 follows src0");
        exp_out(7, 1, 1'b1, "R2 line 7 follows src0");
        exp_out(0, 1, 1'b0, "R5 reserved line 0 ignores mux");
        step();
        src[0] = 1'b0;
        exp_out(4, 1, 1'b0, "R2 line 4 falls with src0");
        step();

        // R3: reselect line 4 to source 37
        src[37] = 1'b1;
        step();
        exp_out(4, 1, 1'b0, "R3 old selection one cycle after write");
        exp_out(4, 2, 1'b1, "R3 new selection two cycles after write");
        wr(8, 16'd37);
        step();
        rd(8, 37, "R3 readback 37");

        // R4: last valid index, then out-of-range values
        src[399] = 1'b1;
        wr(16, 16'd399);
        exp_out(8, 1, 1'b1, "R4 index 399 is valid");
        step();
        src[0] = 1'b1;
        step();
        exp_out(9, 1, 1'b1, "R2 line 9 on src0");
        step();
        exp_out(9, 1, 1'b1, "R4 before out-of-range write");
        exp_out(9, 2, 1'b0, "R4 select 400 drives low");
        wr(18, 16'd400);
        step();
        exp_out(9, 2, 1'b0, "R4 aliasing select 0x1025 drives low");
        wr(18, 16'h1025);
        step();
        src[0] = 1'b0;
        step();

        // R5: reserved line 3
        exp_out(3, 2, 1'b0, "R5 reserved line ignores select write");
        wr(6, 16'd37);
        step();
        rd(6, 0, "R5 reserved write ignored, reads safe");
        fixed[3] = 1'b1;
        exp_out(3, 1, 1'b1, "R5 reserved forwards fixed high");
        step();
        fixed[3] = 1'b0;
        exp_out(3, 1, 1'b0, "R5 reserved forwards fixed low");
        step();

        // R6: skipped lines 10 and 133
        exp_out(10, 2, 1'b0, "R6 skipped line ignores mux");
        wr(20, 16'd37);
        step();
        rd(20, 37, "R6 skipped line keeps written select");
        fixed[10]  = 1'b1;
        fixed[133] = 1'b1;
        exp_out(10, 1, 1'b1, "R6 skipped line 10 forwards fixed");
        exp_out(133, 1, 1'b1, "R6 skipped line 133 forwards fixed");
        step();
        fixed[10]  = 1'b0;
        fixed[133] = 1'b0;
        exp_out(10, 1, 1'b0, "R6 skipped line 10 fixed low");
        step();

        // R7: read and write line 4 in one cycle
        wr_en = 1'b1;
        rd_en = 1'b1;
        addr  = ADDR_W'(8);
        wdata = 16'd55;
        exp_rd(1, 37, "R7 same-cycle read returns old value");
        exp_out(4, 1, 1'b1, "R7 old source still routed");
        exp_out(4, 2, 1'b0, "R7 new source routed");
        step();
        wr_en = 1'b0;
        rd_en = 1'b0;
        rd(8, 55, "R7 later read returns new value");

        // R8: outside the window and misaligned
        wr(320, 16'd7);
        rd(320, 0, "R8 beyond window reads zero");
        wr(9, 16'h22);
        rd(8, 55, "R8 misaligned write left line 4 alone");
        rd(9, 0, "R8 misaligned read is zero");
        rd(1023, 0, "R8 top offset reads zero");

        // R2: toggle the routed source
        for (int i = 0; i < 6; i++) begin
            src[55] = i[0];
            exp_out(4, 1, i[0], "R2 toggle pattern");
            step();
        end

        repeat (4) step();
        chk("scoreboard drained", 32'(sb_q.size()), 32'd0);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

endmodule